// File: doc/BRIEF.md
# Selectable-Digit Seven-Segment Router

This block shows one decimal digit out of four on a four-digit seven-segment display. Its data input holds four packed 4-bit digit values. A 2-bit select input picks one of them. A single shared glyph encoder turns the picked value into a seven-segment pattern. A 1-to-4 demultiplexer then sends that pattern to the segment bus of the selected display position only.

Each display position has its own separate 7-line segment bus. Every position that is not selected gets all-zero segment lines, so at most one digit is lit at any time. The block is purely combinational. It has no clock and no stored state, so the outputs follow the present inputs alone.

The demultiplexer is a binary tree of 1-to-2 stages. Each level of the tree is steered by a 1-to-2 line decoder fed by one select bit. The most significant select bit steers the first level.

Top module: `seg_digit_router`

## Requirements
- R1: Digit position k takes its value from `digits_in[4k+3:4k]` and drives `seg_out[7k+6:7k]`. Within a digit bus, bit 0 is segment a, and bits 1 to 6 are b, c, d, e, f, g. A 1 means lit.
- R2: For a selected value from 0 to 9, the selected bus shows the usual glyph. Segment layout: a is the top, b the upper right, c the lower right, d the bottom, e the lower left, f the upper left, g the middle. a is dark for 1 and 4. b is dark for 5 and 6. c is dark only for 2. d is dark for 1, 4 and 7. e is lit only for 0, 2, 6 and 8. f is dark for 1, 2, 3 and 7. g is dark for 0, 1 and 7.
- R3: When the selected value is 10 to 15, all 28 segment outputs are 0.
- R4: Every digit position other than the one named by `digit_sel` has all seven segment lines at 0.
- R5: At no time does more than one digit bus have any segment lit.
- R6: The three unselected digit values have no effect on any output.
- R7: The outputs depend only on the present inputs. The same final input values give the same outputs, whichever order the select and data inputs changed in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits_in | input | 16 | Four packed 4-bit digit values, digit 0 in the low nibble |
| digit_sel | input | 2 | Index of the digit position to light |
| seg_out | output | 28 | Four 7-bit active-high segment buses, digit 0 in the low bits |

## Verification
The bench builds the block with its default of four digit positions. At that size the input space is small enough to sweep fully. All four select values are run against all sixteen values of the selected nibble, including the six undefined codes. The other nibbles are filled with changing values, so the bench can see any leakage from an unselected digit into the output. Further checks pin down the bit placement at both ends of the bus, show that unselected nibbles have no effect, and show that the result does not depend on the order in which inputs change.

// File: rtl/seg_route_pkg.sv
package seg_route_pkg;

    localparam int NIB_W    = 4;
    localparam int SEG_W    = 7;
    localparam int MAX_CODE = 9;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Packed from MSB to LSB: g at bit 6, a at bit 0.
    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } seg_fields_t;

    function automatic seg_fields_t glyph(input nib_t v);
        seg_fields_t s;
        s = '0;
        case (v)
            4'd0: s = '{g:1'b0, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd1: s = '{g:1'b0, f:1'b0, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b0};
            4'd2: s = '{g:1'b1, f:1'b0, e:1'b1, d:1'b1, c:1'b0, b:1'b1, a:1'b1};
            4'd3: s = '{g:1'b1, f:1'b0, e:1'b0, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd4: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b0};
            4'd5: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b1, c:1'b1, b:1'b0, a:1'b1};
            4'd6: s = '{g:1'b1, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b0, a:1'b1};
            4'd7: s = '{g:1'b0, f:1'b0, e:1'b0, d:1'b0, c:1'b1, b:1'b1, a:1'b1};
            4'd8: s = '{g:1'b1, f:1'b1, e:1'b1, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            4'd9: s = '{g:1'b1, f:1'b1, e:1'b0, d:1'b1, c:1'b1, b:1'b1, a:1'b1};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_nibble_mux.sv
module seg_nibble_mux
    import seg_route_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic [DIGITS*NIB_W-1:0] data,
    input  logic [SEL_W-1:0]        sel,
    output nib_t                    nib
);

    nib_t lanes [DIGITS];

    for (genvar k = 0; k < DIGITS; k++) begin : g_lane
        assign lanes[k] = data[k*NIB_W +: NIB_W];
    end

    always_comb begin
        nib = '0;
        for (int k = 0; k < DIGITS; k++) begin
            if (sel == SEL_W'(k)) nib = lanes[k];
        end
    end

endmodule

// File: rtl/seg_glyph_enc.sv
module seg_glyph_enc
    import seg_route_pkg::*;
(
    input  nib_t value,
    output seg_t seg
);

    seg_fields_t fields;

    always_comb begin
        fields = glyph(value);
        seg    = seg_t'(fields);
    end

    // R2
    always_comb begin
        if (value <= nib_t'(MAX_CODE)) begin
            valid_code_lit_chk: assert (seg != '0);
        end
    end

endmodule

// File: rtl/seg_line_dec1.sv
module seg_line_dec1 (
    input  logic       a,
    output logic [1:0] line
);

    assign line[0] = ~a;
    assign line[1] = a;

endmodule

// File: rtl/seg_demux2.sv
module seg_demux2 #(
    parameter int W = 7
) (
    input  logic [W-1:0] din,
    input  logic [1:0]   line,
    output logic [W-1:0] d0,
    output logic [W-1:0] d1
);

    assign d0 = line[0] ? din : '0;
    assign d1 = line[1] ? din : '0;

    // R5
    always_comb begin
        dmx_line_onehot_chk: assert ($onehot(line));
    end

endmodule

// File: rtl/seg_demux_tree.sv
module seg_demux_tree #(
    parameter int DIGITS = 4,
    parameter int W      = 7,
    localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int NODES = 2*DIGITS - 1
) (
    input  logic [W-1:0]        din,
    input  logic [SEL_W-1:0]    sel,
    output logic [DIGITS*W-1:0] dout
);

    logic [NODES-1:0][W-1:0] node;

    assign node[0] = din;

    for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
        logic [1:0] line;
        seg_line_dec1 u_dec (
            .a    (sel[SEL_W-1-l]),
            .line (line)
        );
        for (genvar n = 0; n < (1 << l); n++) begin : g_node
            localparam int IDX = (1 << l) - 1 + n;
            seg_demux2 #(.W(W)) u_dmx (
                .din  (node[IDX]),
                .line (line),
                .d0   (node[2*IDX+1]),
                .d1   (node[2*IDX+2])
            );
        end
    end

    for (genvar k = 0; k < DIGITS; k++) begin : g_leaf
        assign dout[k*W +: W] = node[DIGITS-1+k];
    end

endmodule

// File: rtl/seg_digit_router.sv
module seg_digit_router
    import seg_route_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic [DIGITS*NIB_W-1:0] digits_in,
    input  logic [SEL_W-1:0]        digit_sel,
    output logic [DIGITS*SEG_W-1:0] seg_out
);

    nib_t picked;
    seg_t pattern;

    seg_nibble_mux #(.DIGITS(DIGITS)) u_mux (
        .data (digits_in),
        .sel  (digit_sel),
        .nib  (picked)
    );

    seg_glyph_enc u_enc (
        .value (picked),
        .seg   (pattern)
    );

    seg_demux_tree #(.DIGITS(DIGITS), .W(SEG_W)) u_tree (
        .din  (pattern),
        .sel  (digit_sel),
        .dout (seg_out)
    );

    logic [DIGITS-1:0] lit;
    for (genvar k = 0; k < DIGITS; k++) begin : g_lit
        assign lit[k] = |seg_out[k*SEG_W +: SEG_W];
    end

    always_comb begin
        for (int k = 0; k < DIGITS; k++) begin
            if (digit_sel != SEL_W'(k)) begin
                // R4
                unsel_blank_chk: assert (seg_out[k*SEG_W +: SEG_W] == '0);
            end
        end
        // R5
        single_lit_chk: assert ($onehot0(lit));
        if (picked > nib_t'(MAX_CODE)) begin
            // R3
            bad_code_blank_chk: assert (seg_out == '0);
        end
    end

endmodule

// File: tb/seg_digit_router_bench.sv
module seg_digit_router_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] digits_in;
    logic [1:0]  digit_sel;
    logic [27:0] seg_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    seg_digit_router u_seg_digit_router (
        .digits_in (digits_in),
        .digit_sel (digit_sel),
        .seg_out   (seg_out)
    );

    function automatic logic [6:0] exp_glyph(input int v);
        logic a, b, c, d, e, f, g;
        if (v > 9) return 7'h00;
        a = !(v == 1 || v == 4);
        b = !(v == 5 || v == 6);
        c = (v != 2);
        d = !(v == 1 || v == 4 || v == 7);
        e = (v == 0 || v == 2 || v == 6 || v == 8);
        f = !(v == 1 || v == 2 || v == 3 || v == 7);
        g = !(v == 0 || v == 1 || v == 7);
        return {g, f, e, d, c, b, a};
    endfunction

    function automatic logic [27:0] exp_out(input logic [15:0] d, input int s);
        logic [27:0] r;
        r = '0;
        r[s*7 +: 7] = exp_glyph(int'(d[s*4 +: 4]));
        return r;
    endfunction

    task automatic apply(input logic [15:0] d, input logic [1:0] s);
        @(posedge clk);
        digits_in = d;
        digit_sel = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%07h expected=%07h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [27:0] first;
        digits_in = '0;
        digit_sel = '0;
        @(negedge clk);
        // Initial all-zero inputs: digit 0 shows the zero glyph
        check("R2 initial", seg_out, 28'h000003F);

        // R1 bit placement at both ends
        apply(16'h0008, 2'd0);
        check("R1 low digit", seg_out, 28'h000007F);
        apply(16'h8000, 2'd3);
        check("R1 high digit", seg_out, 28'h7F << 21);
        apply(16'h0010, 2'd1);
        check("R1 digit1 one", seg_out, 28'h06 << 7);

        // Full sweep: every select against every value, varying neighbours
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                d = '0;
                for (int k = 0; k < 4; k++) d[k*4 +: 4] = 4'((v + 3*k + s) % 16);
                d[s*4 +: 4] = 4'(v);
                apply(d, 2'(s));
                if (v > 9) check("R3 undefined code", seg_out, 28'h0);
                else       check("R2 glyph", seg_out, exp_out(d, s));
                for (int k = 0; k < 4; k++) begin
                    if (k != s) check("R4 unselected blank", {21'h0, seg_out[k*7 +: 7]}, 28'h0);
                end
                checks++;
                if ($countones({|seg_out[27:21], |seg_out[20:14], |seg_out[13:7], |seg_out[6:0]}) > 1) begin
                    errors++;
                    $display("FAIL R5: actual=%07h expected=one digit lit", seg_out);
                end
            end
        end

        // R6: changing unselected nibbles has no effect
        apply(16'h0500, 2'd2);
        first = seg_out;
        check("R6 baseline", first, 28'h6D << 14);
        for (int p = 0; p < 8; p++) begin
            d = 16'(p * 16'h1357) & 16'hF0FF;
            d[11:8] = 4'd5;
            apply(d, 2'd2);
            check("R6 neighbours ignored", seg_out, first);
        end

        // R7: order of change does not matter
        apply(16'h0123, 2'd0);
        apply(16'h4567, 2'd0);
        apply(16'h4567, 2'd3);
        first = seg_out;
        apply(16'h0123, 2'd0);
        apply(16'h0123, 2'd3);
        apply(16'h4567, 2'd3);
        check("R7 order independent", seg_out, first);
        check("R7 expected value", seg_out, exp_out(16'h4567, 3));

        finish_run();
    end

endmodule